// File: doc/BRIEF.md
# Sampling ADC Serial Command and Readout Port

This block is the digital side of a multichannel sampling converter. A host frames each transfer by pulling a read-enable low. During the transfer it clocks an 8-bit command word in on a data input, using a serial clock. At the same time it receives the most recent conversion result on a data output, MSB first. A rising edge on the convert input starts a conversion and BUSY is held while it runs. The converter itself is a stub with a fixed latency. It latches a supplied 16-bit sample word at the start of a conversion and returns it with the configuration field of the command mixed into its upper bits. This makes it possible to see which command produced which result.

The command word has two parts. The upper six bits select channel and span and are passed to the converter. The two lowest bits request the power modes. A command takes effect for the next conversion, so every readout reflects the word sent one transfer earlier. All host pins are resynchronised to the system clock. A four-state machine tracks the power modes and the conversion:

- ST_IDLE: waiting for a conversion request.
- ST_CONV: a conversion is in progress.
- ST_NAP: light power-down.
- ST_SLEEP: deep power-down.

The transitions are:

- ST_IDLE to ST_CONV on a convert edge.
- ST_IDLE to ST_SLEEP on a sleep word.
- ST_CONV to ST_IDLE, ST_NAP or ST_SLEEP when the conversion finishes, according to the pending power request.
- ST_NAP to ST_IDLE on a run word, or to ST_SLEEP on a sleep word.
- ST_SLEEP to ST_IDLE on any word whose sleep bit is clear.

Top module: `adc_serial_port`

## Requirements
- R1: The command word is taken from `sdi` on the first eight rising `sck` edges of a transfer, first bit into bit 7. Any later rising edges in the same transfer leave the captured word unchanged.
- R2: While `rd_n` is high, `sdo_oe` is low (the output is high-impedance), and `sck` and `sdi` have no effect. While `rd_n` is low, `sdo_oe` is high.
- R3: When `rd_n` falls, the stored result is loaded for readout. `sdo` then presents it MSB first and advances by one bit on each falling `sck` edge.
- R4: A rising `convst` edge in ST_IDLE starts a conversion. `busy` then stays high for exactly CONV_CYCLES clock cycles; this latency is clamped to the 5 µs budget.
- R5: A rising `convst` edge while `busy` is high is ignored: the running conversion is not extended and no second conversion follows it.
- R6: A conversion uses the configuration field, bits 7:2, of the last word completed before it starts. The stub's result is `{field ^ sample_in[15:10], sample_in[9:0]}`, and it is read out in the following transfer. The result register changes only when a conversion finishes.
- R7: Every transfer is 16 bits long. With RES_BITS of 14 or 12, the lowest 2 or 4 result bits are sent as zeros.
- R8: A word with bit 0 (sleep) set moves ST_IDLE to ST_SLEEP at once. In ST_SLEEP, `convst` starts nothing until a word with bit 0 clear arrives.
- R9: A word with bit 1 (nap) set and bit 0 clear allows exactly one further conversion, after which the block enters ST_NAP. There `convst` is ignored until a word with both bits clear returns it to ST_IDLE.
- R10: If a conversion start and a word completion fall in the same cycle, the conversion uses the previously held configuration. The new word's power request then applies when that conversion ends.
- R11: After reset, `busy` and `sdo_oe` are low and the stored result is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck | input | 1 | Host serial clock |
| sdi | input | 1 | Host command data |
| rd_n | input | 1 | Active-low transfer enable |
| convst | input | 1 | Conversion request, rising edge |
| sample_in | input | 16 | Sample word supplied to the conversion stub |
| sdo | output | 1 | Result data, valid while `sdo_oe` is high |
| sdo_oe | output | 1 | Output enable for `sdo`; low means high-impedance |
| busy | output | 1 | High while a conversion runs |

## Verification
Two of the block's functions can land in the same clock cycle: the eighth rising `sck` edge that completes a command word, and a `convst` edge that starts a conversion. The bench provokes this by raising `convst` in the same timestep as that eighth `sck` edge. Because both pins pass through synchronisers of equal depth, the two events arrive together. The outcome is judged at the ports. The following readout must carry the configuration held before that word. A later `convst` must start nothing, which shows the sleep request took effect only after the coinciding conversion.

// File: rtl/adc_port_pkg.sv
package adc_port_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_CONV  = 2'd1,
        ST_NAP   = 2'd2,
        ST_SLEEP = 2'd3
    } port_state_e;

    typedef enum logic [1:0] {
        PM_RUN   = 2'd0,
        PM_NAP   = 2'd1,
        PM_SLEEP = 2'd2
    } pwr_req_e;

    // Keep the stub latency inside the conversion budget, never below one cycle
    function automatic int lat_clamp(input int req, input int budget);
        if (req < 1)
            return 1;
        else if (req > budget)
            return budget;
        else
            return req;
    endfunction

    function automatic pwr_req_e decode_pwr(input logic nap_bit, input logic sleep_bit);
        if (sleep_bit)
            return PM_SLEEP;
        else if (nap_bit)
            return PM_NAP;
        else
            return PM_RUN;
    endfunction

endpackage

// File: rtl/adc_in_sync.sv
module adc_in_sync #(
    parameter int               N       = 4,
    parameter int               STAGES  = 2,
    parameter logic [N-1:0]     RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] din,
    output logic [N-1:0] dout
);

    logic [N-1:0] stg [STAGES];

    genvar k;
    generate
        for (k = 0; k < STAGES; k++) begin : g_stage
            if (k == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n)
                        stg[k] <= RST_VAL;
                    else
                        stg[k] <= din;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n)
                        stg[k] <= RST_VAL;
                    else
                        stg[k] <= stg[k-1];
                end
            end
        end
    endgenerate

    assign dout = stg[STAGES-1];

endmodule

// File: rtl/adc_shift_port.sv
module adc_shift_port #(
    parameter int WORD_BITS = 8,
    parameter int DATA_BITS = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 open_xfer,
    input  logic                 active,
    input  logic                 sck_rise,
    input  logic                 sck_fall,
    input  logic                 sdi_lvl,
    input  logic [DATA_BITS-1:0] load_word,
    output logic                 word_done,
    output logic [WORD_BITS-1:0] word,
    output logic                 sdo_bit
);

    localparam int CW = $clog2(WORD_BITS + 1);

    logic [CW-1:0]        bit_cnt;
    logic [WORD_BITS-1:0] sh_in;
    logic [DATA_BITS-1:0] sh_out;
    logic                 take_bit;

    assign take_bit = active && !open_xfer && sck_rise && (bit_cnt < CW'(WORD_BITS));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt <= '0;
            sh_in   <= '0;
            sh_out  <= '0;
        end else if (open_xfer) begin
            bit_cnt <= '0;
            sh_out  <= load_word;
        end else if (active) begin
            if (take_bit) begin
                sh_in   <= {sh_in[WORD_BITS-2:0], sdi_lvl};
                bit_cnt <= bit_cnt + 1'b1;
            end
            if (sck_fall)
                sh_out <= {sh_out[DATA_BITS-2:0], 1'b0};
        end
    end

    assign word_done = take_bit && (bit_cnt == CW'(WORD_BITS - 1));
    assign word      = {sh_in[WORD_BITS-2:0], sdi_lvl};
    assign sdo_bit   = sh_out[DATA_BITS-1];

endmodule

// File: rtl/adc_conv_stub.sv
module adc_conv_stub #(
    parameter int DATA_BITS = 16,
    parameter int RES_BITS  = 16,
    parameter int SEL_BITS  = 6,
    parameter int LAT       = 20
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic [SEL_BITS-1:0]  sel_in,
    input  logic [DATA_BITS-1:0] sample_in,
    output logic                 done,
    output logic [DATA_BITS-1:0] result
);

    localparam int CW  = (LAT > 1) ? $clog2(LAT) : 1;
    localparam int PAD = DATA_BITS - RES_BITS;

    logic                 running;
    logic [CW-1:0]        cnt;
    logic [SEL_BITS-1:0]  sel_q;
    logic [DATA_BITS-1:0] samp_q;
    logic [DATA_BITS-1:0] raw;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            running <= 1'b0;
            cnt     <= '0;
            sel_q   <= '0;
            samp_q  <= '0;
        end else if (start && !running) begin
            running <= 1'b1;
            cnt     <= '0;
            sel_q   <= sel_in;
            samp_q  <= sample_in;
        end else if (running) begin
            if (done)
                running <= 1'b0;
            else
                cnt <= cnt + 1'b1;
        end
    end

    assign done = running && (cnt == CW'(LAT - 1));
    assign raw  = {sel_q ^ samp_q[DATA_BITS-1 -: SEL_BITS], samp_q[DATA_BITS-SEL_BITS-1:0]};

    generate
        if (PAD > 0) begin : g_pad
            assign result = {raw[DATA_BITS-1:PAD], {PAD{1'b0}}};
        end else begin : g_full
            assign result = raw;
        end
    endgenerate

endmodule

// File: rtl/adc_serial_port.sv
module adc_serial_port
    import adc_port_pkg::*;
#(
    parameter int DATA_BITS   = 16,
    parameter int RES_BITS    = 16,
    parameter int WORD_BITS   = 8,
    parameter int CLK_MHZ     = 50,
    parameter int BUDGET_NS   = 5000,
    parameter int CONV_CYCLES = 20,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 sck,
    input  logic                 sdi,
    input  logic                 rd_n,
    input  logic                 convst,
    input  logic [DATA_BITS-1:0] sample_in,
    output logic                 sdo,
    output logic                 sdo_oe,
    output logic                 busy
);

    localparam int SEL_BITS   = WORD_BITS - 2;
    localparam int BUDGET_CYC = CLK_MHZ * BUDGET_NS / 1000;
    localparam int LAT        = lat_clamp(CONV_CYCLES, BUDGET_CYC);

    // Synchronised pins: {convst, rd_n, sdi, sck}
    logic [3:0] sync_q;
    logic       sck_l, sdi_l, rd_l, cv_l;
    logic       sck_p, rd_p, cv_p;
    logic       sck_rise, sck_fall, rd_fall, cv_rise;

    adc_in_sync #(
        .N       (4),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (4'b0100)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   ({convst, rd_n, sdi, sck}),
        .dout  (sync_q)
    );

    assign {cv_l, rd_l, sdi_l, sck_l} = sync_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sck_p <= 1'b0;
            rd_p  <= 1'b1;
            cv_p  <= 1'b0;
        end else begin
            sck_p <= sck_l;
            rd_p  <= rd_l;
            cv_p  <= cv_l;
        end
    end

    assign sck_rise = sck_l & ~sck_p;
    assign sck_fall = ~sck_l & sck_p;
    assign rd_fall  = ~rd_l & rd_p;
    assign cv_rise  = cv_l & ~cv_p;

    // Serial shift path
    logic                 word_done;
    logic [WORD_BITS-1:0] word;
    logic                 sdo_bit;
    logic [DATA_BITS-1:0] result_q;

    adc_shift_port #(
        .WORD_BITS (WORD_BITS),
        .DATA_BITS (DATA_BITS)
    ) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .open_xfer (rd_fall),
        .active    (~rd_l),
        .sck_rise  (sck_rise),
        .sck_fall  (sck_fall),
        .sdi_lvl   (sdi_l),
        .load_word (result_q),
        .word_done (word_done),
        .word      (word),
        .sdo_bit   (sdo_bit)
    );

    // Command registers: field for the next conversion, pending power request
    logic [SEL_BITS-1:0] cfg_q;
    pwr_req_e            pwr_q;
    pwr_req_e            word_pwr;
    pwr_req_e            req_now;

    assign word_pwr = decode_pwr(word[1], word[0]);
    assign req_now  = word_done ? word_pwr : pwr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
            pwr_q <= PM_RUN;
        end else if (word_done) begin
            cfg_q <= word[WORD_BITS-1:2];
            pwr_q <= word_pwr;
        end
    end

    // Conversion stub
    port_state_e          state_q, state_d;
    logic                 start;
    logic                 conv_done;
    logic [DATA_BITS-1:0] conv_result;

    assign start = (state_q == ST_IDLE) && cv_rise;

    adc_conv_stub #(
        .DATA_BITS (DATA_BITS),
        .RES_BITS  (RES_BITS),
        .SEL_BITS  (SEL_BITS),
        .LAT       (LAT)
    ) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .sel_in    (cfg_q),
        .sample_in (sample_in),
        .done      (conv_done),
        .result    (conv_result)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            result_q <= '0;
        else if (conv_done)
            result_q <= conv_result;
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start)
                    state_d = ST_CONV;
                else if (word_done && word_pwr == PM_SLEEP)
                    state_d = ST_SLEEP;
            end
            ST_CONV: begin
                if (conv_done) begin
                    unique case (req_now)
                        PM_SLEEP: state_d = ST_SLEEP;
                        PM_NAP:   state_d = ST_NAP;
                        default:  state_d = ST_IDLE;
                    endcase
                end
            end
            ST_NAP: begin
                if (word_done) begin
                    unique case (word_pwr)
                        PM_SLEEP: state_d = ST_SLEEP;
                        PM_NAP:   state_d = ST_NAP;
                        default:  state_d = ST_IDLE;
                    endcase
                end
            end
            ST_SLEEP: begin
                if (word_done && word_pwr != PM_SLEEP)
                    state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        busy   = (state_q == ST_CONV);
        sdo_oe = ~rd_l;
        sdo    = sdo_oe & sdo_bit;
    end

endmodule

// File: rtl/adc_port_checker.sv
module adc_port_checker
    import adc_port_pkg::*;
#(
    parameter int DATA_BITS   = 16,
    parameter int CLK_MHZ     = 50,
    parameter int BUDGET_NS   = 5000,
    parameter int CONV_CYCLES = 20
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 rd_n,
    input  logic                 busy,
    input  logic                 sdo_oe,
    input  logic                 word_done,
    input  port_state_e          state_q,
    input  logic [DATA_BITS-1:0] result_q
);

    localparam int LAT = lat_clamp(CONV_CYCLES, CLK_MHZ * BUDGET_NS / 1000);

    int   run_len;
    logic got_word;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_len  <= 0;
            got_word <= 1'b0;
        end else begin
            run_len  <= busy ? run_len + 1 : 0;
            if (!sdo_oe)
                got_word <= 1'b0;
            else if (word_done)
                got_word <= 1'b1;
        end
    end

    assert_one_word_R1: assert property (@(posedge clk) disable iff (!rst_n)
        word_done |-> !got_word);

    assert_hiz_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rd_n, 2) |-> !sdo_oe);

    assert_busy_len_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (run_len == LAT));

    assert_result_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !$fell(busy) |-> $stable(result_q));

    // Also covers R9: no conversion leaves a power-down state directly
    assert_start_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> ($past(state_q) == ST_IDLE));

endmodule

bind adc_serial_port adc_port_checker #(
    .DATA_BITS   (DATA_BITS),
    .CLK_MHZ     (CLK_MHZ),
    .BUDGET_NS   (BUDGET_NS),
    .CONV_CYCLES (CONV_CYCLES)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_n      (rd_n),
    .busy      (busy),
    .sdo_oe    (sdo_oe),
    .word_done (word_done),
    .state_q   (state_q),
    .result_q  (result_q)
);

// File: tb/tb_adc_serial_port.sv
`timescale 1ns/1ps
module tb_adc_serial_port;

    localparam int CONV = 20;
    localparam int NV   = 6;
    // {command word (bits 1:0 = 00), sample}
    localparam logic [23:0] VEC [NV] = '{
        {8'hA4, 16'h1234},
        {8'h5C, 16'hABCD},
        {8'hFC, 16'hFFFF},
        {8'h00, 16'h0000},
        {8'h38, 16'h5A5A},
        {8'h80, 16'h03FF}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sck = 1'b0, sdi = 1'b0, rd_n = 1'b1, convst = 1'b0;
    logic [15:0] sample_in = '0;
    logic        sdo16, oe16, busy16;
    logic        sdo14, oe14, busy14;
    logic        sdo12, oe12, busy12;

    int n_run  = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    adc_serial_port #(.RES_BITS(16), .CONV_CYCLES(CONV)) dut (
        .clk(clk), .rst_n(rst_n), .sck(sck), .sdi(sdi), .rd_n(rd_n), .convst(convst),
        .sample_in(sample_in), .sdo(sdo16), .sdo_oe(oe16), .busy(busy16));

    adc_serial_port #(.RES_BITS(14), .CONV_CYCLES(CONV)) dut_r14 (
        .clk(clk), .rst_n(rst_n), .sck(sck), .sdi(sdi), .rd_n(rd_n), .convst(convst),
        .sample_in(sample_in), .sdo(sdo14), .sdo_oe(oe14), .busy(busy14));

    adc_serial_port #(.RES_BITS(12), .CONV_CYCLES(CONV)) dut_r12 (
        .clk(clk), .rst_n(rst_n), .sck(sck), .sdi(sdi), .rd_n(rd_n), .convst(convst),
        .sample_in(sample_in), .sdo(sdo12), .sdo_oe(oe12), .busy(busy12));

    function automatic logic [15:0] raw(input logic [5:0] c, input logic [15:0] s);
        return {c ^ s[15:10], s[9:0]};
    endfunction

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One framed transfer: 8 command bits, then 8 extra edges with sdi=1 (R1)
    task automatic xfer(input logic [7:0] w, input bit cv_at_last,
                        output logic [15:0] r16, output logic [15:0] r14, output logic [15:0] r12);
        rd_n = 1'b0;
        #200;
        chk("R2 oe low-rd", {15'd0, oe16}, 16'd1);
        for (int b = 0; b < 16; b++) begin
            sdi = (b < 8) ? w[7-b] : 1'b1;
            #100;
            r16[15-b] = sdo16;
            r14[15-b] = sdo14;
            r12[15-b] = sdo12;
            if (b == 7 && cv_at_last) convst = 1'b1;
            sck = 1'b1;
            #100;
            sck = 1'b0;
        end
        #200;
        rd_n   = 1'b1;
        convst = 1'b0;
        sdi    = 1'b0;
        #200;
    endtask

    // Request a conversion; count cycles with busy high. Optional retrigger while busy (R5)
    task automatic conv(input logic [15:0] s, input bit retrig, output int n);
        sample_in = s;
        convst = 1'b1;
        n = 0;
        for (int c = 0; c < 400; c++) begin
            #20;
            if (c == 5) convst = 1'b0;
            if (retrig && c == 12) convst = 1'b1;
            if (retrig && c == 16) convst = 1'b0;
            if (busy16) n++;
            else if (n > 0) break;
            if (c > 60 && n == 0) break;
        end
        convst = 1'b0;
    endtask

    task automatic chk_read(input string req, input logic [15:0] r16, input logic [15:0] r14,
                            input logic [15:0] r12, input logic [15:0] e);
        chk(req, r16, e);
        chk({req, " R7 res14"}, r14, e & 16'hFFFC);
        chk({req, " R7 res12"}, r12, e & 16'hFFF0);
    endtask

    initial begin : watchdog
        #(20 * 150000);
        n_run++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin : main
        logic [15:0] r16, r14, r12;
        logic [15:0] e;
        int          n, extra;
        logic [5:0]  pcfg;
        logic [15:0] psamp;

        #3;
        #200;
        // R11: reset state
        chk("R11 busy", {15'd0, busy16}, 16'd0);
        chk("R11 sdo_oe", {15'd0, oe16}, 16'd0);
        rst_n = 1'b1;
        #100;

        // Table walk: each readout reflects the previous word (R6, R3, R7, R1, R4)
        pcfg = '0; psamp = '0;
        for (int i = 0; i < NV; i++) begin
            xfer(VEC[i][23:16], 1'b0, r16, r14, r12);
            if (i == 0) chk_read("R11 result zero", r16, r14, r12, 16'h0000);
            else        chk_read("R6 R3 R1 pipeline", r16, r14, r12, raw(pcfg, psamp));
            conv(VEC[i][15:0], 1'b0, n);
            chk("R4 busy length", 16'(n), 16'(CONV));
            pcfg  = VEC[i][23:18];
            psamp = VEC[i][15:0];
        end
        xfer(8'h00, 1'b0, r16, r14, r12);
        chk_read("R6 R3 last", r16, r14, r12, raw(pcfg, psamp));

        // R2: clocking a sleep word with rd_n high has no effect
        for (int b = 0; b < 8; b++) begin
            sdi = 1'b1;
            #100; sck = 1'b1; #100; sck = 1'b0;
            chk("R2 sdo_oe high-z", {15'd0, oe16}, 16'd0);
        end
        conv(16'hC3A5, 1'b0, n);
        chk("R2 not asleep", 16'(n), 16'(CONV));
        xfer(8'h00, 1'b0, r16, r14, r12);
        chk_read("R2 cfg unchanged", r16, r14, r12, raw(6'h00, 16'hC3A5));

        // R5: convst during busy is ignored
        conv(16'h7E81, 1'b1, n);
        chk("R5 busy length", 16'(n), 16'(CONV));
        extra = 0;
        for (int c = 0; c < 40; c++) begin #20; if (busy16) extra++; end
        chk("R5 no second conversion", 16'(extra), 16'd0);

        // R8: sleep word blocks conversions until a wake word
        xfer({6'h15, 2'b01}, 1'b0, r16, r14, r12);
        chk_read("R5 result", r16, r14, r12, raw(6'h00, 16'h7E81));
        conv(16'h1111, 1'b0, n);
        chk("R8 no start in sleep", 16'(n), 16'd0);
        xfer({6'h2A, 2'b00}, 1'b0, r16, r14, r12);
        chk_read("R8 result unchanged", r16, r14, r12, raw(6'h00, 16'h7E81));
        conv(16'h2468, 1'b0, n);
        chk("R8 wakes", 16'(n), 16'(CONV));
        xfer(8'h00, 1'b0, r16, r14, r12);
        chk_read("R8 wake cfg", r16, r14, r12, raw(6'h2A, 16'h2468));

        // R9: nap after exactly one more conversion
        xfer({6'h0F, 2'b10}, 1'b0, r16, r14, r12);
        conv(16'h9753, 1'b0, n);
        chk("R9 one more conversion", 16'(n), 16'(CONV));
        conv(16'h0F0F, 1'b0, n);
        chk("R9 no start in nap", 16'(n), 16'd0);
        xfer({6'h33, 2'b00}, 1'b0, r16, r14, r12);
        chk_read("R9 nap conv result", r16, r14, r12, raw(6'h0F, 16'h9753));
        conv(16'h8421, 1'b0, n);
        chk("R9 wakes from nap", 16'(n), 16'(CONV));
        xfer(8'h00, 1'b0, r16, r14, r12);
        chk_read("R9 wake cfg", r16, r14, r12, raw(6'h33, 16'h8421));

        // R10: conversion start and word completion in the same cycle
        xfer({6'h21, 2'b00}, 1'b0, r16, r14, r12);
        sample_in = 16'h6B2D;
        xfer({6'h12, 2'b01}, 1'b1, r16, r14, r12);
        conv(16'hFFFF, 1'b0, n);
        chk("R10 sleep after coinciding conversion", 16'(n), 16'd0);
        xfer(8'h00, 1'b0, r16, r14, r12);
        e = raw(6'h21, 16'h6B2D);
        chk_read("R10 old cfg used", r16, r14, r12, e);
        conv(16'h0001, 1'b0, n);
        chk("R10 wakes", 16'(n), 16'(CONV));

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule